// File: doc/BRIEF.md
# Suspend Modulation Clock Throttler

This block slows a processor by pulsing an active-low suspend output. While the output is low, the core is idle. While it is high, the core runs. The pattern repeats: a run interval is followed by an idle interval. Each interval lasts a programmable number of base ticks. A free-running prescaler divides the system clock into those ticks, and at the default settings one tick is 32 microseconds. The average speed of the core is the full speed times RUN / (RUN + IDLE).

Software programs the block through a small byte-wide register port with a combinational read-back. It has these registers:
- an enable register;
- an 8-bit run-interval count;
- an 8-bit idle-interval count;
- a power-management enable register;
- two speedup timeouts.

Activity on the interrupt or video event inputs can pause throttling when the matching speedup is enabled. An accepted event forces the core to full speed at once and loads a hold timer. When that timer runs out, modulation restarts, beginning with a run interval.

Top module: `smod_throttle`

## Requirements
- R1: After reset, `susp_n` is 1, `speedup_active` is 0 and every register reads 0.
- R2: Register addresses and read-back:
  - Address 0 is the enable register. Only bit 0 is stored; bit 0 = 1 enables modulation.
  - Address 1 is the run (idle-phase-free) count, 8 bits. Address 2 is the idle count, 8 bits.
  - Address 3 is the power-management register. Bits 2:0 are stored: bit 0 is the global enable, bit 1 the interrupt speedup enable and bit 2 the video speedup enable.
  - Address 4 is the interrupt timeout and address 5 the video timeout.
  - Addresses 6 and 7 read 0, and writes to them change nothing.
- R3: While the enable bit is 0, `susp_n` stays 1.
- R4: When enabled with both counts non-zero, each low stretch of `susp_n` lasts exactly idle×TICK_DIV clocks. Each high stretch lasts exactly run×TICK_DIV clocks.
- R5: When enabled with the idle count at 0, `susp_n` stays 1. This includes the case where both counts are 0.
- R6: When enabled with the run count at 0 and the idle count non-zero, `susp_n` stays low without a break.
- R7: A count written in the middle of an interval does not change that interval. It applies from the next interval of the same kind.
- R8: An accepted interrupt event drives `susp_n` to 1 on the next clock edge and sets `speedup_active`. With timeout T, the high stretch that follows lasts between (T×SPD_UNIT+run)×TICK_DIV and (T×SPD_UNIT+1+run)×TICK_DIV+1 clocks. After it, modulation resumes and `speedup_active` returns to 0.
- R9: An event is ignored when the global enable bit or its own enable bit is 0. The low stretch in progress keeps its full length.
- R10: A new accepted event while the hold timer is running reloads the timer with the full timeout.
- R11: A video event loads the video timeout, not the interrupt timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend to the core |
| speedup_active | output | 1 | Hold timer is running |

## Verification
The timing of each result is as follows:
- Read-back is combinational, so it is checked 1 ns after the read address is driven.
- Register writes land on the next clock edge.
- The enable bit reaches `susp_n` on the second edge after the write.
- An accepted event raises `susp_n` on the first edge after it is sampled.

Interval lengths are counted at the inactive clock edge as whole runs of equal samples, and each is compared with count×TICK_DIV. A hold depends on where the prescaler stands when the event arrives, so its end can fall anywhere inside one tick window. The bench therefore checks the hold against the closed bounds stated in R8.

// File: rtl/smod_pkg.sv
package smod_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 8;

    localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
    localparam logic [ADDR_W-1:0] A_RUN    = 3'd1;
    localparam logic [ADDR_W-1:0] A_IDLE   = 3'd2;
    localparam logic [ADDR_W-1:0] A_PM     = 3'd3;
    localparam logic [ADDR_W-1:0] A_IRQ_TO = 3'd4;
    localparam logic [ADDR_W-1:0] A_VID_TO = 3'd5;

    localparam int PM_GLOBAL = 0;
    localparam int PM_IRQ    = 1;
    localparam int PM_VID    = 2;
    localparam int PM_W      = 3;

    typedef enum logic [1:0] {
        PH_HALT = 2'd0,
        PH_RUN  = 2'd1,
        PH_IDLE = 2'd2
    } phase_e;
endpackage

// File: rtl/smod_tick.sv
module smod_tick #(
    parameter int TICK_DIV = 8000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_t;

    tick_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == LAST) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
        end else begin
            s_d.cnt  = s_q.cnt + CW'(1);
            s_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = s_q.tick;

    generate
        if (TICK_DIV > 1) begin : g_gap
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.tick |=> !s_q.tick); // R4
        end
    endgenerate
endmodule

// File: rtl/smod_regs.sv
module smod_regs
    import smod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              mod_en,
    output logic [CNT_W-1:0]  run_cnt,
    output logic [CNT_W-1:0]  idle_cnt,
    output logic              irq_ok,
    output logic              vid_ok,
    output logic [CNT_W-1:0]  irq_to,
    output logic [CNT_W-1:0]  vid_to
);
    typedef struct packed {
        logic             en;
        logic [PM_W-1:0]  pm;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] idle;
        logic [CNT_W-1:0] irq_to;
        logic [CNT_W-1:0] vid_to;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                A_CFG:    r_d.en     = wr_data[0];
                A_RUN:    r_d.run    = wr_data[CNT_W-1:0];
                A_IDLE:   r_d.idle   = wr_data[CNT_W-1:0];
                A_PM:     r_d.pm     = wr_data[PM_W-1:0];
                A_IRQ_TO: r_d.irq_to = wr_data[CNT_W-1:0];
                A_VID_TO: r_d.vid_to = wr_data[CNT_W-1:0];
                default:  r_d        = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CFG:    rd_data = {{(DATA_W-1){1'b0}}, r_q.en};
            A_RUN:    rd_data = DATA_W'(r_q.run);
            A_IDLE:   rd_data = DATA_W'(r_q.idle);
            A_PM:     rd_data = {{(DATA_W-PM_W){1'b0}}, r_q.pm};
            A_IRQ_TO: rd_data = DATA_W'(r_q.irq_to);
            A_VID_TO: rd_data = DATA_W'(r_q.vid_to);
            default:  rd_data = '0;
        endcase
    end

    assign mod_en   = r_q.en;
    assign run_cnt  = r_q.run;
    assign idle_cnt = r_q.idle;
    assign irq_ok   = r_q.pm[PM_GLOBAL] & r_q.pm[PM_IRQ];
    assign vid_ok   = r_q.pm[PM_GLOBAL] & r_q.pm[PM_VID];
    assign irq_to   = r_q.irq_to;
    assign vid_to   = r_q.vid_to;

    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > A_VID_TO) |=> $stable(r_q)); // R2
endmodule

// File: rtl/smod_speedup.sv
module smod_speedup
    import smod_pkg::*;
#(
    parameter int SPD_UNIT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             irq_evt,
    input  logic             vid_evt,
    input  logic             irq_ok,
    input  logic             vid_ok,
    input  logic [CNT_W-1:0] irq_to,
    input  logic [CNT_W-1:0] vid_to,
    output logic             hold_o,
    output logic             active_o
);
    localparam int T_W = CNT_W + ((SPD_UNIT > 1) ? $clog2(SPD_UNIT) : 0) + 1;
    localparam logic [T_W-1:0] UNIT = T_W'(SPD_UNIT);

    typedef struct packed {
        logic [T_W-1:0] cnt;
    } spd_t;

    spd_t s_d, s_q;
    logic acc_irq, acc_vid;
    logic [T_W-1:0] irq_load, vid_load;

    assign acc_irq  = irq_evt & irq_ok;
    assign acc_vid  = vid_evt & vid_ok;
    assign irq_load = T_W'(irq_to) * UNIT;
    assign vid_load = T_W'(vid_to) * UNIT;

    always_comb begin
        s_d = s_q;
        if (acc_irq && acc_vid) begin
            s_d.cnt = (irq_load > vid_load) ? irq_load : vid_load;
        end else if (acc_irq) begin
            s_d.cnt = irq_load;
        end else if (acc_vid) begin
            s_d.cnt = vid_load;
        end else if (tick && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - T_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = (s_q.cnt != '0);
    assign hold_o   = active_o | acc_irq | acc_vid;

    AST_EVENT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_irq && irq_to != '0) |=> active_o); // R8
    AST_VIDEO_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vid && vid_to != '0) |=> active_o); // R11
    AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !acc_irq && !acc_vid) |=> $stable(s_q.cnt)); // R10
endmodule

// File: rtl/smod_phase.sv
module smod_phase
    import smod_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             mod_en,
    input  logic             hold,
    input  logic [CNT_W-1:0] run_cnt,
    input  logic [CNT_W-1:0] idle_cnt,
    output logic             susp_n
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] rem;
        logic             susp_n;
    } ph_t;

    ph_t s_d, s_q;

    function automatic ph_t enter(input logic want_idle,
                                  input logic [CNT_W-1:0] r,
                                  input logic [CNT_W-1:0] i);
        ph_t n;
        n = '0;
        n.susp_n = 1'b1;
        if (want_idle && i != '0) begin
            n.ph  = PH_IDLE;
            n.rem = i;
        end else if (r != '0) begin
            n.ph  = PH_RUN;
            n.rem = r;
        end else if (i != '0) begin
            n.ph  = PH_IDLE;
            n.rem = i;
        end else begin
            n.ph  = PH_HALT;
            n.rem = '0;
        end
        return n;
    endfunction

    always_comb begin
        s_d = s_q;
        if (!mod_en || hold) begin
            s_d.ph  = PH_HALT;
            s_d.rem = '0;
        end else if (tick) begin
            case (s_q.ph)
                PH_HALT: s_d = enter(1'b0, run_cnt, idle_cnt);
                PH_RUN: begin
                    if (s_q.rem > CNT_W'(1)) s_d.rem = s_q.rem - CNT_W'(1);
                    else                     s_d = enter(1'b1, run_cnt, idle_cnt);
                end
                PH_IDLE: begin
                    if (s_q.rem > CNT_W'(1)) s_d.rem = s_q.rem - CNT_W'(1);
                    else                     s_d = enter(1'b0, run_cnt, idle_cnt);
                end
                default: s_d.ph = PH_HALT;
            endcase
        end
        s_d.susp_n = (s_d.ph != PH_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.susp_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign susp_n = s_q.susp_n;

    AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && mod_en && !hold) |=> $stable(s_q.ph)); // R7
    AST_ZERO_STAYS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_HALT && idle_cnt == '0) |=> s_q.ph != PH_IDLE); // R5
    AST_IDLE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_HALT) |-> s_q.rem != '0); // R4
endmodule

// File: rtl/smod_throttle.sv
module smod_throttle
    import smod_pkg::*;
#(
    parameter int TICK_DIV = 8000,
    parameter int SPD_UNIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_evt,
    input  logic              vid_evt,
    output logic              susp_n,
    output logic              speedup_active
);
    logic             tick;
    logic             mod_en, irq_ok, vid_ok, hold;
    logic [CNT_W-1:0] run_cnt, idle_cnt, irq_to, vid_to;

    smod_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    smod_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .mod_en(mod_en), .run_cnt(run_cnt), .idle_cnt(idle_cnt),
        .irq_ok(irq_ok), .vid_ok(vid_ok), .irq_to(irq_to), .vid_to(vid_to)
    );

    smod_speedup #(.SPD_UNIT(SPD_UNIT)) u_spd (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .irq_evt(irq_evt), .vid_evt(vid_evt),
        .irq_ok(irq_ok), .vid_ok(vid_ok), .irq_to(irq_to), .vid_to(vid_to),
        .hold_o(hold), .active_o(speedup_active)
    );

    smod_phase u_phase (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .mod_en(mod_en), .hold(hold),
        .run_cnt(run_cnt), .idle_cnt(idle_cnt),
        .susp_n(susp_n)
    );

    AST_DISABLED_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> susp_n); // R3
    AST_HOLD_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> susp_n); // R8
    AST_IGNORED_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_ok && !vid_ok && !speedup_active) |=> !speedup_active); // R9
endmodule

// File: tb/smod_throttle_tb.sv
module smod_throttle_tb;
    localparam int TD = 4;
    localparam int SU = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_evt = 1'b0;
    logic       vid_evt = 1'b0;
    logic       susp_n;
    logic       speedup_active;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    smod_throttle #(.TICK_DIV(TD), .SPD_UNIT(SU)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_evt(irq_evt), .vid_evt(vid_evt),
        .susp_n(susp_n), .speedup_active(speedup_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input int a, input int exp, input string req);
        rd_addr = 3'(a);
        #1;
        check(rd_data == 8'(exp), req, rd_data, exp);
    endtask

    // Count equal samples of susp_n, starting with `start` already counted.
    task automatic run_len(input logic lvl, input int start, output int len);
        len = start;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (susp_n == lvl) len++;
            else break;
        end
    endtask

    // Wait until susp_n goes from high to low at a sample.
    task automatic find_fall(input int limit, output bit found);
        logic prev;
        found = 0;
        prev = susp_n;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (prev && !susp_n) begin found = 1; break; end
            prev = susp_n;
        end
    endtask

    task automatic setup(input int run, input int idle, input int pm);
        wr(0, 0); wr(1, run); wr(2, idle); wr(3, pm); wr(0, 1);
    endtask

    task automatic sweep_one(input int run, input int idle);
        int per, cnt, len;
        bit f;
        setup(run, idle, 0);
        per = (run + idle) * TD;
        if (idle == 0) begin
            cnt = 0;
            for (int k = 0; k < 4 * TD + 3 * per + 8; k++) begin
                @(negedge clk);
                if (!susp_n) cnt++;
            end
            check(cnt == 0, "R5 no idle when idle count is zero", cnt, 0);
        end else if (run == 0) begin
            repeat (3 * TD + 4) @(negedge clk);
            cnt = 0;
            for (int k = 0; k < 3 * idle * TD + 8; k++) begin
                @(negedge clk);
                if (susp_n) cnt++;
            end
            check(cnt == 0, "R6 continuous idle when run count is zero", cnt, 0);
        end else begin
            find_fall(2 * per + 4 * TD + 8, f);
            check(f, "R4 idle stretch starts", f, 1);
            run_len(1'b0, 1, len);
            check(len == idle * TD, "R4 idle stretch length", len, idle * TD);
            run_len(1'b1, 1, len);
            check(len == run * TD, "R4 run stretch length", len, run * TD);
        end
    endtask

    // Event during an idle stretch; returns the high stretch that follows.
    task automatic event_hold(input bit use_vid, output int len);
        bit f;
        find_fall(200, f);
        if (use_vid) vid_evt = 1'b1; else irq_evt = 1'b1;
        @(negedge clk);
        irq_evt = 1'b0; vid_evt = 1'b0;
        check(susp_n == 1'b1, use_vid ? "R11 video event releases at once" : "R8 event releases at once", susp_n, 1);
        check(speedup_active == 1'b1, use_vid ? "R11 hold timer running" : "R8 hold timer running", speedup_active, 1);
        run_len(1'b1, 1, len);
    endtask

    initial begin
        int cnt, len, lo, hi;
        bit f;
        int vals[5] = '{0, 1, 2, 3, 5};
        repeat (3) @(negedge clk);
        check(susp_n == 1'b1, "R1 suspend released in reset", susp_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(susp_n == 1'b1, "R1 suspend released after reset", susp_n, 1);
        check(speedup_active == 1'b0, "R1 no hold after reset", speedup_active, 0);
        for (int a = 0; a < 8; a++) rd_check(a, 0, "R1 register reset value");

        // R2 register map
        wr(1, 8'hA5); wr(2, 8'h3C); wr(3, 8'hFF); wr(4, 8'h81); wr(5, 8'h7E);
        wr(6, 8'hFF); wr(7, 8'h55);
        rd_check(1, 8'hA5, "R2 run count");
        rd_check(2, 8'h3C, "R2 idle count");
        rd_check(3, 8'h07, "R2 pm bits");
        rd_check(4, 8'h81, "R2 interrupt timeout");
        rd_check(5, 8'h7E, "R2 video timeout");
        rd_check(6, 0, "R2 reserved address 6");
        rd_check(7, 0, "R2 reserved address 7");
        wr(0, 8'hFE);
        rd_check(0, 0, "R2 enable stores bit 0 only");
        wr(0, 8'hFF);
        rd_check(0, 1, "R2 enable bit set");
        wr(0, 0);

        // R3 disabled
        wr(1, 2); wr(2, 3); wr(3, 0);
        cnt = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!susp_n) cnt++;
        end
        check(cnt == 0, "R3 no idle while disabled", cnt, 0);

        // R4 R5 R6 sweep
        foreach (vals[i]) foreach (vals[j]) sweep_one(vals[i], vals[j]);

        // R7 mid-interval change: run 2, idle 3, idle rewritten to 1
        setup(2, 3, 0);
        find_fall(200, f);
        len = 1;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'd1;
        if (!susp_n) len++;
        @(negedge clk);
        wr_en = 1'b0;
        if (!susp_n) len++;
        run_len(1'b0, len, len);
        check(len == 3 * TD, "R7 current idle keeps old length", len, 3 * TD);
        run_len(1'b1, 1, len);
        check(len == 2 * TD, "R7 run stretch unchanged", len, 2 * TD);
        run_len(1'b0, 1, len);
        check(len == 1 * TD, "R7 new idle length applied", len, TD);

        // R8 interrupt hold, timeout 3
        wr(4, 3); wr(5, 6);
        setup(2, 3, 8'h07);
        event_hold(0, len);
        lo = (3 * SU + 2) * TD; hi = (3 * SU + 1 + 2) * TD + 1;
        check(len >= lo && len <= hi, "R8 hold length lower/upper bound", len, lo);
        check(speedup_active == 1'b0, "R8 hold ended", speedup_active, 0);
        run_len(1'b0, 1, len);
        check(len == 3 * TD, "R8 modulation resumes", len, 3 * TD);

        // R11 video hold, timeout 6
        event_hold(1, len);
        lo = (6 * SU + 2) * TD; hi = (6 * SU + 1 + 2) * TD + 1;
        check(len >= lo && len <= hi, "R11 video hold length", len, lo);

        // R10 retrigger after 16 cycles
        find_fall(200, f);
        irq_evt = 1'b1;
        @(negedge clk);
        irq_evt = 1'b0;
        len = 1;
        for (int k = 1; k < 16; k++) begin
            @(negedge clk);
            if (susp_n) len++;
        end
        irq_evt = 1'b1;
        @(negedge clk);
        irq_evt = 1'b0;
        if (susp_n) len++;
        run_len(1'b1, len, len);
        lo = 16 + (3 * SU + 2) * TD; hi = 16 + (3 * SU + 1 + 2) * TD + 1;
        check(len >= lo && len <= hi, "R10 retrigger extends hold", len, lo);

        // R9 ignored events: no global enable, then global only
        wr(3, 8'h06);
        for (int v = 0; v < 2; v++) begin
            find_fall(200, f);
            irq_evt = 1'b1; vid_evt = 1'b1;
            @(negedge clk);
            irq_evt = 1'b0; vid_evt = 1'b0;
            len = susp_n ? 1 : 2;
            run_len(1'b0, len, len);
            check(len == 3 * TD, "R9 ignored event keeps idle stretch", len, 3 * TD);
            check(speedup_active == 1'b0, "R9 ignored event arms nothing", speedup_active, 0);
            wr(3, 8'h01);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule